// File: doc/BRIEF.md
# Hash Accelerator Control Register File

This block is the 32-bit register front end of a keyed-hash accelerator. It accepts simple single-cycle read and write requests that carry a byte address, write data and byte strobes. It holds the configuration, a 256-bit secret key, an error code and three interrupt sources. It turns writes to a command register into one-cycle start and finish pulses for the hash engine. It passes the engine's FIFO status and digest words back to software.

While the engine is busy, the configuration and the key are locked. A configuration write in that window is dropped without any indication. A key write in that window is dropped, loads an error code and raises the error interrupt. Digest words can be read with the bytes of each word reversed, and the order of the words stays the same.

Top module: `hacc_regs`

## Requirements
- R1: The configuration register at byte offset 0x08 holds hmac enable in bit 0, hash enable in bit 1, input byte-swap in bit 2 and digest byte-swap in bit 3. Bits 31:4 read as zero. The four bits drive the matching `cfg_*` outputs.
- R2: A write changes only the bytes whose strobe bit is set. For the command register and the interrupt-state register, a data bit counts only if its byte strobe is set.
- R3: A configuration write made while `busy` is high leaves the stored value unchanged. The same write is accepted once `busy` has fallen.
- R4: Eight key words sit at byte offsets 0x20 + 4*i. Word i drives `key_o[255-32*i -: 32]`, so word 0 is the most significant. Key reads return zero.
- R5: A key write made while `busy` is high leaves the key unchanged. It loads the error-code register (offset 0x14) with 0x00000001 and sets interrupt-state bit 2.
- R6: Writing 1 to bit 0 of the command register (offset 0x0C) while not busy produces a one-cycle `start_pulse`. `busy` is set at the same edge. A start written while busy is ignored. Command reads return zero.
- R7: Writing 1 to bit 1 of the command register produces a one-cycle `proc_pulse` only while `busy` is high and no finish has yet been accepted in the current operation. Otherwise it is ignored.
- R8: An `eng_done` pulse clears `busy` and sets interrupt-state bit 0.
- R9: The interrupt-state register (offset 0x00) holds done in bit 0, fifo-empty in bit 1 and error in bit 2. Bit 1 is set when `fifo_empty_i` rises. Writing 1 to a bit clears it, and a set event in the same cycle wins over the clear. The enable register is at offset 0x04, and each `irq_*` output equals its state bit ANDed with its enable bit.
- R10: The status register (offset 0x10) returns `fifo_empty_i` in bit 0, `fifo_full_i` in bit 1 and `fifo_count_i` in bits 8:4.
- R11: Digest word i is at byte offset 0x40 + 4*i and returns `digest_i[255-32*i -: 32]`. It reads zero when hash enable is 0. When digest byte-swap is 1, the four bytes of each word are reversed and the word order is kept.
- R12: Read data and `rsp_valid` appear one cycle after a read request. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Byte write strobes |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| cfg_hmac_en | output | 1 | Keyed mode enable |
| cfg_sha_en | output | 1 | Hash enable |
| cfg_endian_swap | output | 1 | Input byte-swap setting |
| cfg_digest_swap | output | 1 | Digest byte-swap setting |
| key_o | output | 256 | Secret key, word 0 in the top bits |
| start_pulse | output | 1 | One-cycle start command |
| proc_pulse | output | 1 | One-cycle finish command |
| busy | output | 1 | Engine operation in progress |
| eng_done | input | 1 | Engine finished pulse |
| digest_i | input | 256 | Digest from the engine, word 0 in the top bits |
| fifo_empty_i | input | 1 | Message FIFO empty |
| fifo_full_i | input | 1 | Message FIFO full |
| fifo_count_i | input | 5 | Message FIFO entry count |
| irq_done | output | 1 | Done interrupt |
| irq_fifo_empty | output | 1 | FIFO-empty interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The assertions check the following on every cycle:
- the configuration and the key never change while busy;
- both command pulses last one cycle;
- a finish pulse appears only inside an operation, and busy rises only together with a start pulse;
- an engine-done pulse ends the operation and sets the done bit.

Only the bench's scenarios can show the rest. That covers the register layout and the strobe merging, and the refused-key error code. It also covers the byte reversal and zeroing of digest words, the write-one-to-clear behaviour with its set-wins priority, the fifo-empty edge detection, and the one-cycle read latency.

// File: rtl/hacc_regs_pkg.sv
package hacc_regs_pkg;
  // word offsets (byte offset / 4)
  localparam int unsigned W_INTR_STATE = 0;
  localparam int unsigned W_INTR_EN    = 1;
  localparam int unsigned W_CFG        = 2;
  localparam int unsigned W_CMD        = 3;
  localparam int unsigned W_STATUS     = 4;
  localparam int unsigned W_ERR        = 5;
  localparam int unsigned W_KEY0       = 8;

  localparam int unsigned IRQ_DONE   = 0;
  localparam int unsigned IRQ_FEMPTY = 1;
  localparam int unsigned IRQ_ERR    = 2;
  localparam int unsigned NUM_IRQ    = 3;

  localparam logic [31:0] ERR_KEY_BUSY = 32'h0000_0001;

  typedef struct packed {
    logic digest_swap;
    logic endian_swap;
    logic sha_en;
    logic hmac_en;
  } cfg_t;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] merge_bytes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  strb);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = strb[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/hacc_cmd_ctrl.sv
module hacc_cmd_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic proc_req,
  input  logic eng_done,
  output logic start_pulse,
  output logic proc_pulse,
  output logic busy
);
  logic proc_sent;
  logic start_ok, proc_ok;

  assign start_ok = start_req && !busy;
  assign proc_ok  = proc_req && busy && !proc_sent;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_pulse <= 1'b0;
      proc_pulse  <= 1'b0;
      busy        <= 1'b0;
      proc_sent   <= 1'b0;
    end else begin
      start_pulse <= start_ok;
      proc_pulse  <= proc_ok;
      if (start_ok)      busy <= 1'b1;
      else if (eng_done) busy <= 1'b0;
      if (eng_done || !busy) proc_sent <= 1'b0;
      else if (proc_ok)      proc_sent <= 1'b1;
    end
  end
endmodule

// File: rtl/hacc_intr.sv
module hacc_intr #(
  parameter int unsigned NI = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NI-1:0] set_i,
  input  logic [NI-1:0] clr_i,
  input  logic          en_we,
  input  logic [NI-1:0] en_d,
  output logic [NI-1:0] state_q,
  output logic [NI-1:0] en_q,
  output logic [NI-1:0] irq_q
);
  logic [NI-1:0] state_nxt, en_nxt;

  assign state_nxt = (state_q & ~clr_i) | set_i;   // set wins
  assign en_nxt    = en_we ? en_d : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      en_q    <= '0;
      irq_q   <= '0;
    end else begin
      state_q <= state_nxt;
      en_q    <= en_nxt;
      irq_q   <= state_nxt & en_nxt;
    end
  end
endmodule

// File: rtl/hacc_digest_view.sv
module hacc_digest_view import hacc_regs_pkg::*; #(
  parameter int unsigned NW = 8,
  localparam int unsigned IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [NW*32-1:0] digest_i,
  input  logic [IW-1:0]    idx,
  input  logic             sha_en,
  input  logic             swap,
  output logic [31:0]      word_o
);
  logic [31:0] words [NW];
  logic [31:0] raw;

  for (genvar i = 0; i < NW; i++) begin : g_split
    assign words[i] = digest_i[NW*32-1-32*i -: 32];
  end

  assign raw    = words[idx];
  assign word_o = !sha_en ? 32'h0 : (swap ? bswap32(raw) : raw);
endmodule

// File: rtl/hacc_regs.sv
module hacc_regs import hacc_regs_pkg::*; #(
  parameter int unsigned NW    = 8,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [31:0]      req_wdata,
  input  logic [3:0]       req_wstrb,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             cfg_hmac_en,
  output logic             cfg_sha_en,
  output logic             cfg_endian_swap,
  output logic             cfg_digest_swap,
  output logic [NW*32-1:0] key_o,
  output logic             start_pulse,
  output logic             proc_pulse,
  output logic             busy,
  input  logic             eng_done,
  input  logic [NW*32-1:0] digest_i,
  input  logic             fifo_empty_i,
  input  logic             fifo_full_i,
  input  logic [CNT_W-1:0] fifo_count_i,
  output logic             irq_done,
  output logic             irq_fifo_empty,
  output logic             irq_err
);
  localparam int unsigned WAW    = AW - 2;
  localparam int unsigned DIG_W0 = W_KEY0 + NW;
  localparam int unsigned IW     = (NW > 1) ? $clog2(NW) : 1;

  logic [WAW-1:0] waddr;
  logic           wr, rd, unused_addr_lsb;
  assign waddr           = req_addr[AW-1:2];
  assign unused_addr_lsb = ^req_addr[1:0];
  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  logic hit_is, hit_ie, hit_cfg, hit_cmd, hit_st, hit_err, key_hit, dig_hit;
  assign hit_is  = waddr == WAW'(W_INTR_STATE);
  assign hit_ie  = waddr == WAW'(W_INTR_EN);
  assign hit_cfg = waddr == WAW'(W_CFG);
  assign hit_cmd = waddr == WAW'(W_CMD);
  assign hit_st  = waddr == WAW'(W_STATUS);
  assign hit_err = waddr == WAW'(W_ERR);
  assign key_hit = (waddr >= WAW'(W_KEY0)) && (waddr < WAW'(W_KEY0 + NW));
  assign dig_hit = (waddr >= WAW'(DIG_W0)) && (waddr < WAW'(DIG_W0 + NW));

  // command pulses and busy lock
  logic start_req, proc_req;
  assign start_req = wr && hit_cmd && req_wstrb[0] && req_wdata[0];
  assign proc_req  = wr && hit_cmd && req_wstrb[0] && req_wdata[1];

  hacc_cmd_ctrl u_cmd (
    .clk(clk), .rst(rst), .start_req(start_req), .proc_req(proc_req),
    .eng_done(eng_done), .start_pulse(start_pulse), .proc_pulse(proc_pulse), .busy(busy)
  );

  // configuration
  cfg_t cfg_q, cfg_nxt;
  assign cfg_nxt = req_wstrb[0] ? cfg_t'(req_wdata[3:0]) : cfg_q;
  always_ff @(posedge clk) begin
    if (rst)                         cfg_q <= '0;
    else if (wr && hit_cfg && !busy) cfg_q <= cfg_nxt;
  end
  assign cfg_hmac_en     = cfg_q.hmac_en;
  assign cfg_sha_en      = cfg_q.sha_en;
  assign cfg_endian_swap = cfg_q.endian_swap;
  assign cfg_digest_swap = cfg_q.digest_swap;

  // key words
  for (genvar i = 0; i < NW; i++) begin : g_key
    logic [31:0] kw;
    always_ff @(posedge clk) begin
      if (rst) kw <= '0;
      else if (wr && !busy && waddr == WAW'(W_KEY0 + i))
        kw <= merge_bytes(kw, req_wdata, req_wstrb);
    end
    assign key_o[NW*32-1-32*i -: 32] = kw;
  end

  // refused key write -> error code
  logic        key_refused;
  logic [31:0] err_q;
  assign key_refused = wr && key_hit && busy;
  always_ff @(posedge clk) begin
    if (rst)              err_q <= '0;
    else if (key_refused) err_q <= ERR_KEY_BUSY;
  end

  // interrupts
  logic fe_prev;
  always_ff @(posedge clk) begin
    if (rst) fe_prev <= 1'b1;
    else     fe_prev <= fifo_empty_i;
  end

  logic [NUM_IRQ-1:0] irq_set, irq_clr, intr_state, intr_en, irq_vec, en_d;
  always_comb begin
    irq_set             = '0;
    irq_set[IRQ_DONE]   = eng_done;
    irq_set[IRQ_FEMPTY] = fifo_empty_i && !fe_prev;
    irq_set[IRQ_ERR]    = key_refused;
  end
  assign irq_clr = (wr && hit_is && req_wstrb[0]) ? req_wdata[NUM_IRQ-1:0] : '0;
  assign en_d    = req_wdata[NUM_IRQ-1:0];

  hacc_intr #(.NI(NUM_IRQ)) u_intr (
    .clk(clk), .rst(rst), .set_i(irq_set), .clr_i(irq_clr),
    .en_we(wr && hit_ie && req_wstrb[0]), .en_d(en_d),
    .state_q(intr_state), .en_q(intr_en), .irq_q(irq_vec)
  );
  assign irq_done       = irq_vec[IRQ_DONE];
  assign irq_fifo_empty = irq_vec[IRQ_FEMPTY];
  assign irq_err        = irq_vec[IRQ_ERR];

  // digest readout
  logic [31:0] dig_word;
  logic [WAW-1:0] dig_off;
  assign dig_off = waddr - WAW'(DIG_W0);
  hacc_digest_view #(.NW(NW)) u_dig (
    .digest_i(digest_i), .idx(IW'(dig_off)), .sha_en(cfg_q.sha_en),
    .swap(cfg_q.digest_swap), .word_o(dig_word)
  );

  // read path
  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (hit_is)       rd_word[NUM_IRQ-1:0] = intr_state;
    else if (hit_ie)  rd_word[NUM_IRQ-1:0] = intr_en;
    else if (hit_cfg) rd_word[3:0]         = cfg_q;
    else if (hit_st) begin
      rd_word[0]         = fifo_empty_i;
      rd_word[1]         = fifo_full_i;
      rd_word[4 +: CNT_W] = fifo_count_i;
    end
    else if (hit_err) rd_word = err_q;
    else if (dig_hit) rd_word = dig_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_word : '0;
    end
  end
endmodule

// File: rtl/hacc_regs_chk.sv
module hacc_regs_chk #(
  parameter int unsigned NW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_pulse,
  input logic             proc_pulse,
  input logic             busy,
  input logic             eng_done,
  input logic [3:0]       cfg_bits,
  input logic [NW*32-1:0] key_o,
  input logic [2:0]       intr_state
);
  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cfg_bits));
  a_r5_key_locked: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(key_o));
  a_r6_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);
  a_r6_busy_with_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> start_pulse);
  a_r7_proc_inside_op: assert property (@(posedge clk) disable iff (rst)
    proc_pulse |-> busy);
  a_r7_proc_one_cycle: assert property (@(posedge clk) disable iff (rst)
    proc_pulse |=> !proc_pulse);
  a_r8_done_ends_op: assert property (@(posedge clk) disable iff (rst)
    (eng_done && busy) |=> !busy);
  a_r8_done_sets_state: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> intr_state[0]);
endmodule

bind hacc_regs hacc_regs_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst(rst), .start_pulse(start_pulse), .proc_pulse(proc_pulse),
  .busy(busy), .eng_done(eng_done), .cfg_bits(cfg_q), .key_o(key_o),
  .intr_state(intr_state)
);

// File: tb/hacc_regs_bench.sv
module hacc_regs_bench;
  localparam int NW = 8;
  localparam logic [7:0] A_IS = 8'h00, A_IE = 8'h04, A_CFG = 8'h08, A_CMD = 8'h0C,
                         A_ST = 8'h10, A_ERR = 8'h14, A_KEY = 8'h20, A_DIG = 8'h40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_wstrb = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic cfg_hmac_en, cfg_sha_en, cfg_endian_swap, cfg_digest_swap;
  logic [NW*32-1:0] key_o, digest_i;
  logic start_pulse, proc_pulse, busy, eng_done = 1'b0;
  logic fifo_empty_i = 1'b1, fifo_full_i = 1'b0;
  logic [4:0] fifo_count_i = '0;
  logic irq_done, irq_fifo_empty, irq_err;

  hacc_regs u_hacc_regs (.*);

  int errs = 0, checks = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  function automatic logic [31:0] rev_bytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
  function automatic logic [31:0] dw(input int i);
    return {8'(16*i+1), 8'(16*i+2), 8'(16*i+3), 8'(16*i+4)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_wstrb = s;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_wstrb = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  // monitor: compare read responses in order
  always @(negedge clk) begin
    if (rsp_valid) begin
      if (exp_q.size() == 0) check("R12 unexpected response", rsp_rdata, 32'hx);
      else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  logic finished = 1'b0;
  initial begin
    #2_000_000;
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) digest_i[NW*32-1-32*i -: 32] = dw(i);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R6 busy after reset", {31'b0, busy}, 0);
    check("R9 irqs after reset", {29'b0, irq_done, irq_fifo_empty, irq_err}, 0);
    rd(A_ST, 32'h1, "R10 status reset");
    rd(A_CFG, 32'h0, "R1 config reset");

    fifo_count_i = 5'd17; fifo_full_i = 1; fifo_empty_i = 0;
    rd(A_ST, 32'h112, "R10 status fields");

    wr(A_CFG, 32'hB, 4'b0001);
    rd(A_CFG, 32'hB, "R1 config readback");
    check("R1 config outputs", {28'b0, cfg_digest_swap, cfg_endian_swap, cfg_sha_en, cfg_hmac_en}, 32'hB);
    wr(A_CFG, 32'hFFFF_FFF4, 4'b1110);
    rd(A_CFG, 32'hB, "R2 config strobe masked");
    wr(A_CFG, 32'hF, 4'b0001);

    for (int i = 0; i < NW; i++) wr(A_KEY + 8'(4*i), 32'hC0DE_0000 | i, 4'hF);
    check("R4 key word0 on top", key_o[255:224], 32'hC0DE_0000);
    check("R4 key word7 at bottom", key_o[31:0], 32'hC0DE_0007);
    rd(A_KEY + 8'd12, 32'h0, "R4 key reads zero");
    wr(A_KEY + 8'd8, 32'hFFFF_FFFF, 4'b0001);
    check("R2 key byte strobe", key_o[191:160], 32'hC0DE_00FF);

    rd(A_DIG, rev_bytes(dw(0)), "R11 digest0 swapped");
    rd(A_DIG + 8'd28, rev_bytes(dw(7)), "R11 digest7 swapped");
    wr(A_CFG, 32'h3, 4'hF);
    rd(A_DIG, dw(0), "R11 digest0 plain");
    wr(A_CFG, 32'h1, 4'hF);
    rd(A_DIG + 8'd20, 32'h0, "R11 digest zero when hash off");
    wr(A_CFG, 32'h3, 4'hF);
    rd(8'h7C, 32'h0, "R12 unmapped reads zero");

    wr(A_CMD, 32'h2, 4'hF);
    check("R7 finish without start ignored", {31'b0, proc_pulse}, 0);
    check("R7 still idle", {31'b0, busy}, 0);

    wr(A_CMD, 32'h1, 4'hF);
    check("R6 start pulse", {31'b0, start_pulse}, 1);
    check("R6 busy set", {31'b0, busy}, 1);
    @(negedge clk);
    check("R6 start pulse one cycle", {31'b0, start_pulse}, 0);
    rd(A_CMD, 32'h0, "R6 command reads zero");
    wr(A_CMD, 32'h1, 4'hF);
    check("R6 start while busy ignored", {31'b0, start_pulse}, 0);

    wr(A_CFG, 32'h0, 4'hF);
    rd(A_CFG, 32'h3, "R3 config locked while busy");
    wr(A_KEY, 32'hDEAD_BEEF, 4'hF);
    check("R5 key locked while busy", key_o[255:224], 32'hC0DE_0000);
    rd(A_ERR, 32'h1, "R5 error code");
    rd(A_IS, 32'h4, "R5 error state bit");
    check("R9 error irq masked", {31'b0, irq_err}, 0);
    wr(A_IE, 32'h4, 4'b0001);
    check("R9 error irq enabled", {31'b0, irq_err}, 1);

    wr(A_CMD, 32'h2, 4'hF);
    check("R7 finish pulse", {31'b0, proc_pulse}, 1);
    @(negedge clk);
    check("R7 finish pulse one cycle", {31'b0, proc_pulse}, 0);
    wr(A_CMD, 32'h2, 4'hF);
    check("R7 second finish ignored", {31'b0, proc_pulse}, 0);

    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    check("R8 busy cleared by done", {31'b0, busy}, 0);
    rd(A_IS, 32'h5, "R8 done state bit");
    wr(A_IE, 32'h1, 4'b0001);
    check("R9 done irq", {30'b0, irq_done, irq_err}, 32'h2);

    wr(A_IS, 32'h1, 4'b0000);
    rd(A_IS, 32'h5, "R9 clear needs strobe");
    wr(A_IS, 32'h1, 4'b0001);
    rd(A_IS, 32'h4, "R9 write one clears");
    check("R9 done irq cleared", {31'b0, irq_done}, 0);

    @(negedge clk); fifo_empty_i = 1;
    repeat (2) @(negedge clk);
    rd(A_IS, 32'h6, "R9 fifo empty rising edge");

    wr(A_CFG, 32'h5, 4'hF);
    rd(A_CFG, 32'h5, "R3 config accepted when idle");

    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = A_IS; req_wdata = 32'h1; req_wstrb = 4'h1; eng_done = 1;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_wstrb = '0; eng_done = 0;
    rd(A_IS, 32'h7, "R9 set wins over clear");

    repeat (3) @(negedge clk);
    check("R12 all responses seen", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule